// File: doc/BRIEF.md
# Halfword-to-Byte FIFO Packing Port

This block sits between a 16-bit host register port and a small byte queue shared with a serial bus engine. A host halfword write splits into two bytes and queues both. A host halfword read removes up to two bytes and returns them packed into one word. A byte-order input decides which of the two bytes travels first in both directions. The bus engine fills the queue a byte at a time on receive and drains it a byte at a time on transmit.

Each read returns status change pulses that an external status register applies: set pulses and clear pulses on a 16-bit vector. A read that finds exactly one byte left raises a dedicated single-byte flag. A read that drains the queue clears the receive-ready flag and raises the access-ready flag. Any read that finds data clears the receive-overrun flag.

Top module: `halfword_byte_port`

## Requirements
- R1: After reset the queue is empty (`fifoLevel` 0, `engPopValid` 0), `hostRdData` is 0 and `statSet`/`statClr` are 0.
- R2: With `bigEndian` 0, a host write queues `hostWrData[7:0]` first and `hostWrData[15:8]` second.
- R3: With `bigEndian` 1, a host write queues `hostWrData[15:8]` first and `hostWrData[7:0]` second.
- R4: A host write is dropped with no change to queue contents when more than DEPTH-2 bytes (more than 2 by default) are queued.
- R5: A read with two or more bytes queued removes two bytes. With `bigEndian` 0 the first byte lands in bits [7:0] and the second in [15:8]. With `bigEndian` 1 the first byte lands in [15:8] and the second in [7:0].
- R6: A read with exactly one byte queued empties the queue. It returns that byte in the first-byte position with the other half zero, and pulses `statSet` bit 15.
- R7: A read that leaves the queue empty pulses `statClr` bit 3 and `statSet` bit 2. A read that leaves bytes queued pulses neither.
- R8: Every read that finds at least one byte pulses `statClr` bit 11.
- R9: A read of an empty queue returns 0, pulses no status bit and leaves the queue empty.
- R10: When host read and host write strobe in the same cycle, the read is performed and the write is dropped.
- R11: Engine push and pop are dropped in any cycle with a host read or write strobe. A push is dropped when the queue is full. A pop is dropped when the queue is empty. A push wins over a simultaneous pop, and the pop is dropped.
- R12: `hostRdData` and the status pulses appear in the cycle after the read strobe. The pulses last one cycle, and `hostRdData` holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host halfword write strobe |
| hostRdEn | input | 1 | Host halfword read strobe |
| hostWrData | input | 16 | Host write halfword |
| hostRdData | output | 16 | Packed read halfword, registered |
| bigEndian | input | 1 | Byte order select: 1 = upper byte first |
| engPushEn | input | 1 | Bus engine pushes a received byte |
| engPushData | input | 8 | Byte pushed by the engine |
| engPopEn | input | 1 | Bus engine takes the head byte |
| engPopData | output | 8 | Head byte of the queue |
| engPopValid | output | 1 | Queue holds at least one byte |
| fifoLevel | output | 3 | Bytes currently queued |
| statSet | output | 16 | One-cycle status set pulses |
| statClr | output | 16 | One-cycle status clear pulses |

## Verification
The bench targets the single-byte read, the drain-to-empty read, the write offered to a queue that is too full, the empty read, and the collisions between host and engine strobes. A swapped byte order would show the wrong byte at the engine head or in the packed word. A missing write guard would overwrite unread bytes and raise the level past the depth. A single-byte read that treated the stale second slot as data would return a nonzero unused half or leave the level wrong. A wrong drain decision would miss, or falsely raise, the access-ready and receive-ready pulses.

// File: rtl/hwpack_pkg.sv
package hwpack_pkg;
  localparam int STAT_W     = 16;
  localparam int BIT_SINGLE = 15;
  localparam int BIT_OVRUN  = 11;
  localparam int BIT_RXRDY  = 3;
  localparam int BIT_ACCRDY = 2;

  typedef struct packed {
    logic hostRead;
    logic hostWrite;
    logic engPush;
    logic engPop;
  } portStrobe_t;
endpackage

// File: rtl/hwpack_datapath.sv
module hwpack_datapath
  import hwpack_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int BYTE_W = 8,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int HALF_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strobe,
  input  logic              bigEndian,
  input  logic [HALF_W-1:0] wrHalf,
  input  logic [BYTE_W-1:0] pushByte,
  output logic [LVL_W-1:0]  level,
  output logic [BYTE_W-1:0] headByte,
  output logic [HALF_W-1:0] rdPacked
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rdPtr;
  logic [PTR_W-1:0]  wrIdx0;
  logic [PTR_W-1:0]  wrIdx1;
  logic [BYTE_W-1:0] firstByte;
  logic [BYTE_W-1:0] secondByte;
  logic [BYTE_W-1:0] wrFirst;
  logic [BYTE_W-1:0] wrSecond;
  logic              hasTwo;

  assign wrIdx0     = rdPtr + level[PTR_W-1:0];
  assign wrIdx1     = wrIdx0 + PTR_W'(1);
  assign hasTwo     = level >= LVL_W'(2);
  assign firstByte  = (level != '0) ? mem[rdPtr] : '0;
  assign secondByte = hasTwo ? mem[rdPtr + PTR_W'(1)] : '0;
  assign headByte   = firstByte;
  assign wrFirst    = bigEndian ? wrHalf[HALF_W-1:BYTE_W] : wrHalf[BYTE_W-1:0];
  assign wrSecond   = bigEndian ? wrHalf[BYTE_W-1:0] : wrHalf[HALF_W-1:BYTE_W];
  assign rdPacked   = bigEndian ? {firstByte, secondByte} : {secondByte, firstByte};

  always_ff @(posedge clk) begin
    if (strobe.hostWrite) begin
      mem[wrIdx0] <= wrFirst;
      mem[wrIdx1] <= wrSecond;
    end else if (strobe.engPush) begin
      mem[wrIdx0] <= pushByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      level <= '0;
    end else if (strobe.hostRead) begin
      if (level != '0) begin
        rdPtr <= rdPtr + PTR_W'(2);
        level <= hasTwo ? level - LVL_W'(2) : '0;
      end
    end else if (strobe.hostWrite) begin
      level <= level + LVL_W'(2);
    end else if (strobe.engPush) begin
      level <= level + LVL_W'(1);
    end else if (strobe.engPop) begin
      rdPtr <= rdPtr + PTR_W'(1);
      level <= level - LVL_W'(1);
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH)); // R4
  AST_WRITE_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hostWrite |-> level <= LVL_W'(DEPTH - 2)); // R4
  AST_SINGLE_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.hostRead && level == LVL_W'(1)) |=> level == '0); // R6
endmodule

// File: rtl/hwpack_ctrl.sv
module hwpack_ctrl
  import hwpack_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int BYTE_W = 8,
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int HALF_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRdEn,
  input  logic              hostWrEn,
  input  logic              engPushEn,
  input  logic              engPopEn,
  input  logic [LVL_W-1:0]  level,
  input  logic [HALF_W-1:0] rdPacked,
  output portStrobe_t       strobe,
  output logic [HALF_W-1:0] hostRdData,
  output logic [STAT_W-1:0] statSet,
  output logic [STAT_W-1:0] statClr
);
  logic hostBusy;
  logic notEmpty;
  logic isSingle;
  logic drains;

  assign hostBusy = hostRdEn | hostWrEn;
  assign notEmpty = level != '0;
  assign isSingle = level == LVL_W'(1);
  assign drains   = notEmpty && level <= LVL_W'(2);

  always_comb begin
    strobe           = '0;
    strobe.hostRead  = hostRdEn;
    strobe.hostWrite = hostWrEn && !hostRdEn && (level <= LVL_W'(DEPTH - 2));
    strobe.engPush   = engPushEn && !hostBusy && (level < LVL_W'(DEPTH));
    strobe.engPop    = engPopEn && !hostBusy && !strobe.engPush && notEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdData <= '0;
      statSet    <= '0;
      statClr    <= '0;
    end else begin
      statSet <= '0;
      statClr <= '0;
      if (hostRdEn) begin
        hostRdData <= notEmpty ? rdPacked : '0;
        if (notEmpty) begin
          statClr[BIT_OVRUN] <= 1'b1;
          if (isSingle) statSet[BIT_SINGLE] <= 1'b1;
          if (drains) begin
            statSet[BIT_ACCRDY] <= 1'b1;
            statClr[BIT_RXRDY]  <= 1'b1;
          end
        end
      end
    end
  end

  AST_EMPTY_READ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && !notEmpty) |=> (statSet == '0 && statClr == '0 && hostRdData == '0)); // R9
  AST_DRAIN_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && drains) |=> (statSet[BIT_ACCRDY] && statClr[BIT_RXRDY])); // R7
  AST_SINGLE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && isSingle) |=> statSet[BIT_SINGLE]); // R6
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !hostRdEn |=> (statSet == '0 && statClr == '0)); // R12
  AST_ENGINE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    hostBusy |-> !(strobe.engPush || strobe.engPop)); // R11
endmodule

// File: rtl/halfword_byte_port.sv
module halfword_byte_port
  import hwpack_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int BYTE_W = 8,
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int HALF_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [HALF_W-1:0] hostWrData,
  output logic [HALF_W-1:0] hostRdData,
  input  logic              bigEndian,
  input  logic              engPushEn,
  input  logic [BYTE_W-1:0] engPushData,
  input  logic              engPopEn,
  output logic [BYTE_W-1:0] engPopData,
  output logic              engPopValid,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic [STAT_W-1:0] statSet,
  output logic [STAT_W-1:0] statClr
);
  portStrobe_t       strobe;
  logic [HALF_W-1:0] rdPacked;

  hwpack_ctrl #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .hostRdEn(hostRdEn), .hostWrEn(hostWrEn),
    .engPushEn(engPushEn), .engPopEn(engPopEn),
    .level(fifoLevel), .rdPacked(rdPacked),
    .strobe(strobe), .hostRdData(hostRdData),
    .statSet(statSet), .statClr(statClr)
  );

  hwpack_datapath #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .bigEndian(bigEndian), .wrHalf(hostWrData), .pushByte(engPushData),
    .level(fifoLevel), .headByte(engPopData), .rdPacked(rdPacked)
  );

  assign engPopValid = fifoLevel != '0;
endmodule

// File: tb/tb_halfword_byte_port.sv
module tb_halfword_byte_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 0, hostRdEn = 0, bigEndian = 0, engPushEn = 0, engPopEn = 0;
  logic [15:0] hostWrData = '0;
  logic [7:0]  engPushData = '0;
  logic [15:0] hostRdData, statSet, statClr;
  logic [7:0]  engPopData;
  logic        engPopValid;
  logic [2:0]  fifoLevel;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  halfword_byte_port dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .bigEndian(bigEndian),
    .engPushEn(engPushEn), .engPushData(engPushData), .engPopEn(engPopEn),
    .engPopData(engPopData), .engPopValid(engPopValid), .fifoLevel(fifoLevel),
    .statSet(statSet), .statClr(statClr)
  );

  // Behavioural reference: a byte queue updated at every edge.
  byte unsigned q[$];
  logic [15:0] expRd = '0, expSet = '0, expClr = '0;

  always @(posedge clk) begin
    byte unsigned b0, b1;
    if (!rstN) begin
      q.delete(); expRd = '0; expSet = '0; expClr = '0;
    end else begin
      expSet = '0; expClr = '0;
      if (hostRdEn) begin
        if (q.size() == 0) expRd = '0;
        else begin
          expClr[11] = 1'b1;
          b0 = q.pop_front();
          if (q.size() == 0) begin
            expRd = bigEndian ? {b0, 8'h00} : {8'h00, b0};
            expSet[15] = 1'b1;
          end else begin
            b1 = q.pop_front();
            expRd = bigEndian ? {b0, b1} : {b1, b0};
          end
          if (q.size() == 0) begin expSet[2] = 1'b1; expClr[3] = 1'b1; end
        end
      end else if (hostWrEn) begin
        if (q.size() <= 2) begin
          if (bigEndian) begin q.push_back(hostWrData[15:8]); q.push_back(hostWrData[7:0]); end
          else begin q.push_back(hostWrData[7:0]); q.push_back(hostWrData[15:8]); end
        end
      end else if (engPushEn && q.size() < 4) begin
        q.push_back(engPushData);
      end else if (engPopEn && q.size() > 0) begin
        void'(q.pop_front());
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(hostRdData == expRd, "MODEL rdData", hostRdData, expRd);
      check(statSet == expSet && statClr == expClr, "MODEL status",
            {statSet, statClr}, {expSet, expClr});
      check(fifoLevel == q.size(), "MODEL level", fifoLevel, q.size());
      check(engPopValid == (q.size() != 0), "MODEL valid", engPopValid, q.size() != 0);
      if (q.size() != 0) check(engPopData == q[0], "MODEL head", engPopData, q[0]);
    end
  end

  task automatic idleAll();
    hostWrEn = 0; hostRdEn = 0; engPushEn = 0; engPopEn = 0;
  endtask
  task automatic hostWrite(input logic [15:0] d, input logic be);
    hostWrEn = 1; hostWrData = d; bigEndian = be;
    @(negedge clk); idleAll();
  endtask
  task automatic hostRead(input logic be);
    hostRdEn = 1; bigEndian = be;
    @(negedge clk); idleAll();
  endtask
  task automatic engPush(input logic [7:0] d);
    engPushEn = 1; engPushData = d;
    @(negedge clk); idleAll();
  endtask
  task automatic engPop();
    engPopEn = 1;
    @(negedge clk); idleAll();
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      testsRun++; testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    check(fifoLevel == 0 && !engPopValid, "R1 level", fifoLevel, 0);
    check(hostRdData == 0 && statSet == 0 && statClr == 0, "R1 outputs", hostRdData, 0);

    hostWrite(16'h2211, 0);
    check(engPopData == 8'h11, "R2 first byte", engPopData, 8'h11);
    engPop();
    check(engPopData == 8'h22, "R2 second byte", engPopData, 8'h22);
    engPop();

    hostWrite(16'hBBAA, 1);
    check(engPopData == 8'hBB, "R3 first byte", engPopData, 8'hBB);
    engPop(); engPop();

    hostWrite(16'h0201, 0);
    engPush(8'h03);
    hostWrite(16'h0504, 0);
    check(fifoLevel == 3, "R4 write dropped", fifoLevel, 3);

    hostRead(0);
    check(hostRdData == 16'h0201, "R5 little order", hostRdData, 16'h0201);
    check(statClr[11] == 1, "R8 overrun clear", statClr, 16'h0800);
    check(statSet[2] == 0 && statClr[3] == 0, "R7 not drained", statSet, 0);
    check(fifoLevel == 1, "R5 level", fifoLevel, 1);

    hostRead(0);
    check(hostRdData == 16'h0003, "R6 single data", hostRdData, 16'h0003);
    check(statSet == 16'h8004, "R6 R7 set pulses", statSet, 16'h8004);
    check(statClr == 16'h0808, "R7 clear pulses", statClr, 16'h0808);
    check(fifoLevel == 0, "R6 empties", fifoLevel, 0);

    idleAll(); @(negedge clk);
    check(statSet == 0 && statClr == 0, "R12 pulse ends", statSet, 0);
    check(hostRdData == 16'h0003, "R12 data holds", hostRdData, 16'h0003);

    hostRead(0);
    check(hostRdData == 0 && statSet == 0 && statClr == 0, "R9 empty read", hostRdData, 0);
    check(fifoLevel == 0, "R9 level", fifoLevel, 0);

    hostWrite(16'h4433, 1);
    hostRead(1);
    check(hostRdData == 16'h4433, "R5 big order", hostRdData, 16'h4433);
    check(statSet == 16'h0004, "R7 drain two", statSet, 16'h0004);

    engPush(8'h77);
    hostRead(1);
    check(hostRdData == 16'h7700, "R6 big single", hostRdData, 16'h7700);

    hostWrEn = 1; hostRdEn = 1; hostWrData = 16'hCCDD; bigEndian = 0;
    @(negedge clk); idleAll();
    check(fifoLevel == 0, "R10 write dropped", fifoLevel, 0);

    hostWrEn = 1; hostWrData = 16'h0201; engPushEn = 1; engPushData = 8'h99;
    @(negedge clk); idleAll();
    check(fifoLevel == 2, "R11 push blocked", fifoLevel, 2);
    engPush(8'h03); engPush(8'h04); engPush(8'h05);
    check(fifoLevel == 4, "R11 full push dropped", fifoLevel, 4);
    engPushEn = 1; engPushData = 8'h06; engPopEn = 1;
    engPop();
    hostRead(0); hostRead(0);
    engPop();
    check(fifoLevel == 0 && !engPopValid, "R11 empty pop", fifoLevel, 0);

    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      bigEndian = $urandom_range(0, 1);
      hostWrData = 16'($urandom);
      engPushData = 8'($urandom);
      hostRdEn = (r < 2) || (r == 9);
      hostWrEn = (r >= 2 && r < 4) || (r == 9);
      engPushEn = (r >= 4 && r < 7);
      engPopEn = (r >= 6 && r < 9);
      @(negedge clk);
    end
    idleAll();
    @(negedge clk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule